// File: doc/BRIEF.md
# Floating-Point Register File with Narrow-Value Boxing

This block is the architectural floating-point register file of a core that supports half, single and double precision. It holds 32 words of 64 bits. It has one write port and two combinational read ports. Each port carries a precision code. Each read port also carries an access kind, which tells a raw transfer (store, move to an integer register) apart from an arithmetic operand fetch.

Every value narrower than 64 bits is kept in the low bits of its word, with ones in all bits above it. This rule holds whether the value comes from a load, a move or an arithmetic result. So a narrow value always looks like a negative quiet NaN when it is read at a wider precision.

Reads differ by kind:
- A transfer read returns only the low n bits, zero-extended. It ignores whatever lies above them.
- An arithmetic read checks the upper bits. If they are all ones, the word is delivered as stored, which is already a legal boxed word. If any of them is zero, the read delivers the canonical NaN of the requested precision, boxed with ones, and raises a per-port flag.
- Double-precision accesses pass through untouched.

Top module: `fpr_nanbox_rf`

## Requirements
- R1: A synchronous reset, active high on `rst`, clears all 32 registers to zero. Registers not written since then read back as 64'h0 with a double transfer read.
- R2: A write with precision code 2'b00 (half) stores {48 ones, data[15:0]}. A write with code 2'b01 (single) stores {32 ones, data[31:0]}. The other bits of `wr_data` are discarded.
- R3: A write with precision code 2'b10 (double) or 2'b11 (reserved, treated as double) stores all 64 bits of `wr_data` unchanged.
- R4: A transfer read (kind 0) at half returns {48'h0, word[15:0]}, and at single returns {32'h0, word[31:0]}. The upper bits of the stored word have no effect, and the flag stays 0.
- R5: An arithmetic read (kind 1) at half or single returns the stored word unchanged, with the flag at 0, when every bit above the narrow value is one.
- R6: An arithmetic read at half or single returns the canonical NaN when any bit above the narrow value is zero. The canonical NaN is 16'h7E00 (half) or 32'h7FC00000 (single), with ones in all higher bits. The port's `_nanbox_bad` output is 1 in that case.
- R7: A read at double or reserved precision, of either kind, returns the stored 64-bit word with the flag at 0.
- R8: A write takes effect at the rising clock edge when `wr_en` is 1. A read of the register being written in the same cycle returns the new boxed value. With `wr_en` at 0 the contents are unchanged.
- R9: The two read ports are independent. Each uses only its own address, precision and kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register written |
| wr_prec | input | 2 | Write precision: 00 half, 01 single, 10/11 double |
| wr_data | input | 64 | Write value, narrow values in low bits |
| rd0_addr | input | 5 | Read port 0 register |
| rd0_prec | input | 2 | Read port 0 precision |
| rd0_kind | input | 1 | Read port 0 kind: 0 transfer, 1 arithmetic |
| rd0_data | output | 64 | Read port 0 value |
| rd0_nanbox_bad | output | 1 | Read port 0 substituted a canonical NaN |
| rd1_addr | input | 5 | Read port 1 register |
| rd1_prec | input | 2 | Read port 1 precision |
| rd1_kind | input | 1 | Read port 1 kind: 0 transfer, 1 arithmetic |
| rd1_data | output | 64 | Read port 1 value |
| rd1_nanbox_bad | output | 1 | Read port 1 substituted a canonical NaN |

## Verification
The same stored words are read at several precisions and kinds, so that boxing, truncation and substitution are told apart on one value:
- A single result read as a half operand must be rejected, because its upper 48 bits are not all ones.
- A double whose upper word is one bit short of all ones must also be rejected at single precision.
- A word boxed with ones all the way down to a half value must be accepted at both half and single.

Writes at each precision, including the reserved code, are read back at double through the same-cycle bypass and on later cycles. A disabled write with different data shows that it leaves the register alone. A second reset after the file has been filled, followed by a sweep of all 32 registers, shows that every entry is cleared.

// File: rtl/fpr_nanbox_pkg.sv
package fpr_nanbox_pkg;
    localparam int FLEN  = 64;
    localparam int NREGS = 32;
    localparam int NRD   = 2;

    typedef enum logic [1:0] {
        PREC_HALF   = 2'b00,
        PREC_SINGLE = 2'b01,
        PREC_DOUBLE = 2'b10,
        PREC_RSVD   = 2'b11
    } prec_e;

    typedef enum logic {
        KIND_XFER  = 1'b0,
        KIND_ARITH = 1'b1
    } kind_e;

    localparam logic [15:0] CNAN_HALF   = 16'h7E00;
    localparam logic [31:0] CNAN_SINGLE = 32'h7FC0_0000;
endpackage

// File: rtl/fpr_wr_box.sv
module fpr_wr_box
    import fpr_nanbox_pkg::*;
#(
    parameter int W = FLEN
) (
    input  prec_e        prec,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    always_comb begin
        unique case (prec)
            PREC_HALF:   dout = {{(W-16){1'b1}}, din[15:0]};
            PREC_SINGLE: dout = {{(W-32){1'b1}}, din[31:0]};
            default:     dout = din;
        endcase
    end
endmodule

// File: rtl/fpr_rd_unbox.sv
module fpr_rd_unbox
    import fpr_nanbox_pkg::*;
#(
    parameter int W = FLEN
) (
    input  prec_e        prec,
    input  kind_e        kind,
    input  logic [W-1:0] raw,
    output logic [W-1:0] dout,
    output logic         bad
);
    logic ok_half, ok_single;

    assign ok_half   = &raw[W-1:16];
    assign ok_single = &raw[W-1:32];

    always_comb begin
        dout = raw;
        bad  = 1'b0;
        unique case (prec)
            PREC_HALF: begin
                if (kind == KIND_XFER) begin
                    dout = {{(W-16){1'b0}}, raw[15:0]};
                end else if (!ok_half) begin
                    dout = {{(W-16){1'b1}}, CNAN_HALF};
                    bad  = 1'b1;
                end
            end
            PREC_SINGLE: begin
                if (kind == KIND_XFER) begin
                    dout = {{(W-32){1'b0}}, raw[31:0]};
                end else if (!ok_single) begin
                    dout = {{(W-32){1'b1}}, CNAN_SINGLE};
                    bad  = 1'b1;
                end
            end
            default: begin
                dout = raw;
                bad  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fpr_store.sv
module fpr_store #(
    parameter int W     = 64,
    parameter int DEPTH = 32,
    parameter int PORTS = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [W-1:0]               wr_data,
    input  logic [PORTS-1:0][AW-1:0]   rd_addr,
    output logic [PORTS-1:0][W-1:0]    rd_raw
);
    logic [W-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        assign rd_raw[p] = (wr_en && !rst && wr_addr == rd_addr[p])
                           ? wr_data : regs[rd_addr[p]];
    end
endmodule

// File: rtl/fpr_nanbox_rf.sv
module fpr_nanbox_rf
    import fpr_nanbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [4:0]  wr_addr,
    input  logic [1:0]  wr_prec,
    input  logic [63:0] wr_data,
    input  logic [4:0]  rd0_addr,
    input  logic [1:0]  rd0_prec,
    input  logic        rd0_kind,
    output logic [63:0] rd0_data,
    output logic        rd0_nanbox_bad,
    input  logic [4:0]  rd1_addr,
    input  logic [1:0]  rd1_prec,
    input  logic        rd1_kind,
    output logic [63:0] rd1_data,
    output logic        rd1_nanbox_bad
);
    localparam int AW = $clog2(NREGS);

    logic [FLEN-1:0]           wdata_boxed;
    logic [NRD-1:0][AW-1:0]    rd_addr_v;
    logic [NRD-1:0][1:0]       rd_prec_v;
    logic [NRD-1:0]            rd_kind_v;
    logic [NRD-1:0][FLEN-1:0]  rd_raw_v;
    logic [NRD-1:0][FLEN-1:0]  rd_data_v;
    logic [NRD-1:0]            rd_bad_v;

    assign rd_addr_v = {rd1_addr, rd0_addr};
    assign rd_prec_v = {rd1_prec, rd0_prec};
    assign rd_kind_v = {rd1_kind, rd0_kind};

    fpr_wr_box #(.W(FLEN)) u_box (
        .prec (prec_e'(wr_prec)),
        .din  (wr_data),
        .dout (wdata_boxed)
    );

    fpr_store #(.W(FLEN), .DEPTH(NREGS), .PORTS(NRD)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wdata_boxed),
        .rd_addr (rd_addr_v),
        .rd_raw  (rd_raw_v)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_unbox
        fpr_rd_unbox #(.W(FLEN)) u_unbox (
            .prec (prec_e'(rd_prec_v[p])),
            .kind (kind_e'(rd_kind_v[p])),
            .raw  (rd_raw_v[p]),
            .dout (rd_data_v[p]),
            .bad  (rd_bad_v[p])
        );
    end

    assign rd0_data       = rd_data_v[0];
    assign rd1_data       = rd_data_v[1];
    assign rd0_nanbox_bad = rd_bad_v[0];
    assign rd1_nanbox_bad = rd_bad_v[1];

    // R1: first cycle after reset, a double transfer read with no write sees zero
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !wr_en && rd0_prec == 2'b10 && rd0_kind == 1'b0)
        |-> rd0_data == 64'h0);

    // R4: half transfer reads are zero-extended and never flagged
    a_r4_xfer_half_zero: assert property (@(posedge clk) disable iff (rst)
        (rd0_kind == 1'b0 && rd0_prec == 2'b00)
        |-> (rd0_data[63:16] == 48'h0 && !rd0_nanbox_bad));

    // R5: single arithmetic reads always deliver a legally boxed word
    a_r5_arith_single_boxed: assert property (@(posedge clk) disable iff (rst)
        (rd1_kind == 1'b1 && rd1_prec == 2'b01) |-> (&rd1_data[63:32]));

    // R6: a raised flag always comes with a boxed canonical NaN
    a_r6_flag_is_canon: assert property (@(posedge clk) disable iff (rst)
        rd0_nanbox_bad |-> (rd0_data == {48'hFFFF_FFFF_FFFF, CNAN_HALF} ||
                            rd0_data == {32'hFFFF_FFFF, CNAN_SINGLE}));

    // R7: wide-precision reads never raise the flag
    a_r7_wide_no_flag: assert property (@(posedge clk) disable iff (rst)
        rd1_prec[1] |-> !rd1_nanbox_bad);

    // R8: a write made last cycle is visible as a double transfer read now
    a_r8_write_visible: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && !wr_en && rd0_addr == $past(wr_addr)
         && rd0_prec == 2'b10 && rd0_kind == 1'b0)
        |-> rd0_data == $past(wdata_boxed));
endmodule

// File: tb/fpr_nanbox_rf_test.sv
module fpr_nanbox_rf_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [1:0]  wr_prec = '0;
    logic [63:0] wr_data = '0;
    logic [4:0]  rd0_addr = '0, rd1_addr = '0;
    logic [1:0]  rd0_prec = 2'b10, rd1_prec = 2'b10;
    logic        rd0_kind = 1'b0, rd1_kind = 1'b0;
    logic [63:0] rd0_data, rd1_data;
    logic        rd0_nanbox_bad, rd1_nanbox_bad;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [63:0] model [32];

    typedef struct {
        logic        port;
        logic [63:0] d;
        logic        f;
        string       tag;
    } item_t;
    item_t sb [$];

    always #10 clk = ~clk;

    fpr_nanbox_rf uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_prec(wr_prec), .wr_data(wr_data),
        .rd0_addr(rd0_addr), .rd0_prec(rd0_prec), .rd0_kind(rd0_kind),
        .rd0_data(rd0_data), .rd0_nanbox_bad(rd0_nanbox_bad),
        .rd1_addr(rd1_addr), .rd1_prec(rd1_prec), .rd1_kind(rd1_kind),
        .rd1_data(rd1_data), .rd1_nanbox_bad(rd1_nanbox_bad)
    );

    function automatic logic [63:0] box(input logic [1:0] p, input logic [63:0] v);
        if (p == 2'b00) return {48'hFFFF_FFFF_FFFF, v[15:0]};
        if (p == 2'b01) return {32'hFFFF_FFFF, v[31:0]};
        return v;
    endfunction

    function automatic void exp_read(input logic [63:0] w, input logic [1:0] p,
                                     input logic k, output logic [63:0] d,
                                     output logic f);
        d = w;
        f = 1'b0;
        if (p == 2'b00) begin
            if (!k) d = {48'h0, w[15:0]};
            else if (w[63:16] != 48'hFFFF_FFFF_FFFF) begin
                d = 64'hFFFF_FFFF_FFFF_7E00; f = 1'b1;
            end
        end else if (p == 2'b01) begin
            if (!k) d = {32'h0, w[31:0]};
            else if (w[63:32] != 32'hFFFF_FFFF) begin
                d = 64'hFFFF_FFFF_7FC0_0000; f = 1'b1;
            end
        end
    endfunction

    // Driver: one cycle of stimulus, pushes expected results of both ports
    task automatic step(input logic we, input logic [4:0] wa, input logic [1:0] wp,
                        input logic [63:0] wd,
                        input logic [4:0] a0, input logic [1:0] p0, input logic k0,
                        input logic [4:0] a1, input logic [1:0] p1, input logic k1,
                        input string t0, input string t1);
        item_t it;
        logic [63:0] w;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_prec = wp; wr_data = wd;
        rd0_addr = a0; rd0_prec = p0; rd0_kind = k0;
        rd1_addr = a1; rd1_prec = p1; rd1_kind = k1;
        w = (we && wa == a0) ? box(wp, wd) : model[a0];
        it.port = 1'b0; it.tag = t0;
        exp_read(w, p0, k0, it.d, it.f);
        sb.push_back(it);
        w = (we && wa == a1) ? box(wp, wd) : model[a1];
        it.port = 1'b1; it.tag = t1;
        exp_read(w, p1, k1, it.d, it.f);
        sb.push_back(it);
        if (we) model[wa] = box(wp, wd);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = 64'h0;
    endtask

    // Monitor: compares queued expectations mid-cycle
    initial begin
        item_t it;
        logic [63:0] ad;
        logic        af;
        forever begin
            @(negedge clk);
            #5;
            while (sb.size() > 0) begin
                it = sb.pop_front();
                ad = it.port ? rd1_data : rd0_data;
                af = it.port ? rd1_nanbox_bad : rd0_nanbox_bad;
                checks++;
                if (ad !== it.d || af !== it.f) begin
                    fails++;
                    $display("FAIL %s port%0d: got data=%h flag=%b, expected data=%h flag=%b",
                             it.tag, it.port, ad, af, it.d, it.f);
                end
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2 half write, R8 same-cycle bypass, R5 valid arith half
        step(1, 5'd1, 2'b00, 64'hABCD_0000_5555_1234,
             5'd1, 2'b00, 1, 5'd1, 2'b10, 0, "R8 bypass half arith", "R2 half box");
        // R2 single box; R6 single word read as half operand
        step(1, 5'd2, 2'b01, 64'h1111_2222_3F80_0000,
             5'd2, 2'b10, 0, 5'd2, 2'b00, 1, "R2 single box", "R6 half bad box");
        // R3 double write; R6 single arith bad; R4 single transfer
        step(1, 5'd3, 2'b10, 64'h0000_0001_3F80_0000,
             5'd3, 2'b01, 1, 5'd3, 2'b01, 0, "R6 single bad box", "R4 single xfer");
        // R6 one bit short of boxed; R4 half transfer ignores upper bits
        step(1, 5'd4, 2'b10, 64'hFFFF_FFFE_1234_5678,
             5'd4, 2'b01, 1, 5'd4, 2'b00, 0, "R6 near-boxed", "R4 half xfer");
        // R5 word boxed down to half accepted at half and single
        step(1, 5'd5, 2'b10, 64'hFFFF_FFFF_FFFF_C000,
             5'd5, 2'b00, 1, 5'd5, 2'b01, 1, "R5 half valid", "R5 single valid");
        // R5 half-boxed value as single operand; R4 half transfer; R9 ports differ
        step(0, 5'd0, 2'b00, 64'h0,
             5'd1, 2'b01, 1, 5'd1, 2'b00, 0, "R5 half word single arith", "R9 R4 half xfer");
        // R8 disabled write leaves r1; R7 double arith passthrough
        step(0, 5'd1, 2'b10, 64'hDEAD_BEEF_DEAD_BEEF,
             5'd1, 2'b10, 0, 5'd2, 2'b10, 1, "R8 no write", "R7 double arith");
        // R3 reserved code acts as double; R6 half arith on it
        step(1, 5'd6, 2'b11, 64'h0123_4567_89AB_CDEF,
             5'd6, 2'b11, 1, 5'd6, 2'b00, 1, "R3 R7 reserved prec", "R6 half bad");
        step(0, 5'd0, 2'b00, 64'h0,
             5'd6, 2'b10, 0, 5'd1, 2'b10, 0, "R3 stored reserved", "R8 r1 held");
        // R1 untouched register zero after reset; R7 double read
        step(1, 5'd31, 2'b10, 64'h7FF0_0000_0000_0001,
             5'd31, 2'b10, 1, 5'd0, 2'b10, 0, "R7 double arith", "R1 r0 zero");
        // Fill then reset: all 32 entries zero
        for (int i = 0; i < 32; i++)
            step(1, 5'(i), 2'b10, 64'hA5A5_0000_0000_0000 | 64'(i),
                 5'(i), 2'b10, 0, 5'(i), 2'b01, 1, "R8 fill", "R6 fill single");
        do_reset();
        for (int i = 0; i < 16; i++)
            step(0, 5'd0, 2'b00, 64'h0,
                 5'(2 * i), 2'b10, 0, 5'(2 * i + 1), 2'b10, 0, "R1 cleared", "R1 cleared");
        // R6 zero word as single operand; R4 transfer of zero
        step(0, 5'd0, 2'b00, 64'h0,
             5'd2, 2'b01, 1, 5'd2, 2'b01, 0, "R6 zero word", "R4 zero xfer");
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        #8;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule